// File: doc/BRIEF.md
# Zero-Suppressing Pedestal-Subtraction Sample Processor

The block sits behind an ADC that a multiplexed front end drives. The ADC delivers one 12-bit sample per channel, with channels in ascending order. Each event covers 16, 32, 48 or 64 channels. For every sample the block looks up two stored values for that channel: a cut level and a baseline. A sample that lies strictly above its cut level is kept. The baseline is subtracted from it, and the result is pushed into an internal data queue together with the channel number. Samples at or below the cut level are dropped. Each channel also gets one bit, set or cleared, in an occupancy bitmap, so a reader can see which channels fired without walking the queue.

After the last channel of an event, the block spends one cycle writing a closing word into the queue. That word carries the number of kept channels and an 11-bit running event number. A host loads the per-channel cut levels and baselines through a write port, and in normal use sets each cut level to the baseline plus about three times the channel's noise rms. The downstream reader drains the queue from a first-word-fall-through port. A programmable fill level stops sample intake before stored words could be overrun.

Top module: `zs_ped_proc`

## Requirements
- R1: After reset the queue is empty (`fifo_empty`=1), `almost_full` is low, `smp_ready` is high, and the channel index and event number start at 0.
- R2: An accepted sample whose value is strictly greater than its channel's cut level pushes one data word: `rd_trailer`=0, `rd_data[17:12]`=channel number, `rd_data[11:0]`=sample minus baseline.
- R3: If the baseline exceeds an accepted, kept sample, the stored amplitude is 0, not a wrapped difference.
- R4: An accepted sample equal to or below its cut level pushes no data word.
- R5: `cfg_groups` sets the event length to (cfg_groups+1)*16 channels. In the cycle right after the last channel of an event is accepted, `smp_ready` is low while the closing word is written.
- R6: The closing word has `rd_trailer`=1, `rd_data[17:7]`=event number and `rd_data[6:0]`=count of kept channels in that event.
- R7: The event number increases by one after each closing word is written and wraps from 2047 to 0.
- R8: For every accepted sample, bit (channel mod 16) of bitmap word (event number mod 16)*4 + channel/16 becomes 1 if the sample was kept and 0 otherwise. The word can be read on `bm_rdata` through `bm_raddr`.
- R9: While the queue holds at least `cfg_afull_lvl` words, `almost_full` is high and `smp_ready` is low. No stored word is lost or reordered.
- R10: `rd_data`/`rd_trailer` present the oldest stored word whenever `fifo_empty` is low. A high `rd_en` removes it, and words leave in the order they were written.
- R11: A host write with `cfg_sel`=0 stores a 12-bit cut level. A write with `cfg_sel`=1 stores only the low 8 bits of `cfg_wdata` as the baseline, and the upper 4 bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Host write strobe for the per-channel tables |
| cfg_sel | input | 1 | 0 selects cut level table, 1 selects baseline table |
| cfg_addr | input | 6 | Channel number written |
| cfg_wdata | input | 12 | Value written (baseline uses bits 7:0) |
| cfg_groups | input | 2 | Event length selector, (value+1)*16 channels |
| cfg_afull_lvl | input | 10 | Fill level at which sample intake stops |
| smp_valid | input | 1 | Sample present on smp_data |
| smp_data | input | 12 | ADC sample of the current channel |
| smp_ready | output | 1 | Sample is taken on this edge when smp_valid is high |
| rd_en | input | 1 | Remove the word at the head of the queue |
| rd_data | output | 18 | Head word payload |
| rd_trailer | output | 1 | Head word is a closing word |
| fifo_empty | output | 1 | Queue holds no word |
| almost_full | output | 1 | Queue fill has reached cfg_afull_lvl |
| bm_raddr | input | 6 | Bitmap word address |
| bm_rdata | output | 16 | Bitmap word contents |

## Verification
The assertions check several rules on every cycle. Intake is closed whenever the fill level is reached or the closing word is being written. Occupancy never exceeds the queue depth and moves by at most one word per cycle. Each closing word advances the event number by exactly one, and the kept-channel count never exceeds the channel total. Only the bench's scenarios can show the arithmetic and the contents: the strict comparison at the cut level, clamping to zero, the channel and count fields, the bitmap bit placement, the event-number wrap after 2048 events, and the queue's ordering under backpressure.

// File: rtl/zs_pkg.sv
`timescale 1ns/1ps
package zs_pkg;
  // Channels per selectable group of an event
  localparam int GROUP_CH = 16;

  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_TRAIL = 1'b1
  } ctl_st_t;
endpackage

// File: rtl/zs_cal_mem.sv
`timescale 1ns/1ps
module zs_cal_mem #(
  parameter int NCH   = 64,
  parameter int THR_W = 12,
  parameter int PED_W = 8,
  localparam int AW   = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic             sel,
  input  logic [AW-1:0]    waddr,
  input  logic [THR_W-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [THR_W-1:0] thr,
  output logic [PED_W-1:0] ped
);
  logic [THR_W-1:0] thr_mem [NCH];
  logic [PED_W-1:0] ped_mem [NCH];

  always_ff @(posedge clk) begin
    if (we && !sel) thr_mem[waddr] <= wdata;
    if (we &&  sel) ped_mem[waddr] <= wdata[PED_W-1:0];
  end

  assign thr = thr_mem[raddr];
  assign ped = ped_mem[raddr];
endmodule

// File: rtl/zs_fifo.sv
`timescale 1ns/1ps
module zs_fifo #(
  parameter int DEPTH = 512,
  parameter int W     = 19,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  output logic [W-1:0]  rdata,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] occ
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q, wp_n, rp_n;
  logic [CW-1:0] occ_q, occ_n;
  logic          wr_ok, rd_ok;

  assign empty = (occ_q == '0);
  assign full  = (occ_q == CW'(DEPTH));
  assign wr_ok = we && !full;
  assign rd_ok = re && !empty;

  always_comb begin
    wp_n  = wr_ok ? wp_q + 1'b1 : wp_q;
    rp_n  = rd_ok ? rp_q + 1'b1 : rp_q;
    occ_n = occ_q + CW'(wr_ok) - CW'(rd_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      occ_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      occ_q <= occ_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];
  assign occ   = occ_q;
endmodule

// File: rtl/zs_bitmap.sv
`timescale 1ns/1ps
module zs_bitmap #(
  parameter int WORDS = 64,
  parameter int BW    = 16,
  localparam int WAW  = $clog2(WORDS),
  localparam int BAW  = $clog2(BW)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [WAW-1:0] waddr,
  input  logic [BAW-1:0] wbit,
  input  logic           wval,
  input  logic [WAW-1:0] raddr,
  output logic [BW-1:0]  rdata
);
  logic [BW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr][wbit] <= wval;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/zs_ped_proc.sv
`timescale 1ns/1ps
module zs_ped_proc #(
  parameter int N_CH       = 64,
  parameter int ADC_W      = 12,
  parameter int PED_W      = 8,
  parameter int FIFO_DEPTH = 512,
  parameter int EVT_W      = 11,
  parameter int BM_W       = 16,
  parameter int BM_SLOTS   = 16,
  localparam int CH_AW     = $clog2(N_CH),
  localparam int GRP_LSB   = $clog2(zs_pkg::GROUP_CH),
  localparam int GRP_W     = CH_AW - GRP_LSB,
  localparam int OCC_W     = $clog2(FIFO_DEPTH) + 1,
  localparam int DW        = ADC_W + CH_AW,
  localparam int BM_WORDS  = BM_SLOTS * (N_CH / BM_W),
  localparam int BM_AW     = $clog2(BM_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [CH_AW-1:0] cfg_addr,
  input  logic [ADC_W-1:0] cfg_wdata,
  input  logic [GRP_W-1:0] cfg_groups,
  input  logic [OCC_W-1:0] cfg_afull_lvl,
  input  logic             smp_valid,
  input  logic [ADC_W-1:0] smp_data,
  output logic             smp_ready,
  input  logic             rd_en,
  output logic [DW-1:0]    rd_data,
  output logic             rd_trailer,
  output logic             fifo_empty,
  output logic             almost_full,
  input  logic [BM_AW-1:0] bm_raddr,
  output logic [BM_W-1:0]  bm_rdata
);
  import zs_pkg::*;

  localparam int CNT_W  = CH_AW + 1;
  localparam int SLOT_W = $clog2(BM_SLOTS);
  localparam int BIT_W  = $clog2(BM_W);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  // control state
  ctl_st_t          st_q, st_n;
  logic [CH_AW-1:0] chan_q, chan_n;
  logic [CNT_W-1:0] hits_q, hits_n;
  logic [EVT_W-1:0] evt_q, evt_n;
  logic             trail_st;

  // per-channel lookup
  logic [ADC_W-1:0] thr;
  logic [PED_W-1:0] ped;
  logic [ADC_W-1:0] ped_ext;

  zs_cal_mem #(.NCH(N_CH), .THR_W(ADC_W), .PED_W(PED_W)) cal_i (
    .clk   (clk),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .waddr (cfg_addr),
    .wdata (cfg_wdata),
    .raddr (chan_q),
    .thr   (thr),
    .ped   (ped)
  );

  // sparse scan datapath
  logic             hit, accept, last_ch;
  logic [ADC_W-1:0] amp;
  logic [CH_AW-1:0] last_idx;

  assign ped_ext  = {{(ADC_W-PED_W){1'b0}}, ped};
  assign hit      = smp_data > thr;
  assign amp      = (smp_data > ped_ext) ? (smp_data - ped_ext) : '0;
  assign last_idx = {cfg_groups, {GRP_LSB{1'b1}}};
  assign last_ch  = (chan_q == last_idx);
  assign trail_st = (st_q == ST_TRAIL);

  // data queue
  logic             fifo_we, fifo_full;
  logic [DW:0]      fifo_wdata, fifo_rdata;
  logic [OCC_W-1:0] fifo_occ;
  logic [DW-1:0]    trl_word;

  assign trl_word    = DW'({evt_q, hits_q});
  assign almost_full = (fifo_occ >= cfg_afull_lvl);
  assign smp_ready   = !trail_st && !almost_full && !fifo_full;
  assign accept      = smp_valid && smp_ready;
  assign fifo_we     = (accept && hit) || (trail_st && !fifo_full);
  assign fifo_wdata  = trail_st ? {1'b1, trl_word} : {1'b0, chan_q, amp};

  zs_fifo #(.DEPTH(FIFO_DEPTH), .W(DW + 1)) fifo_i (
    .clk   (clk),
    .rst_n (rst_i_n),
    .we    (fifo_we),
    .wdata (fifo_wdata),
    .re    (rd_en),
    .rdata (fifo_rdata),
    .empty (fifo_empty),
    .full  (fifo_full),
    .occ   (fifo_occ)
  );

  assign rd_trailer = fifo_rdata[DW];
  assign rd_data    = fifo_rdata[DW-1:0];

  // occupancy bitmap
  logic [BM_AW-1:0] bm_waddr;
  assign bm_waddr = {evt_q[SLOT_W-1:0], chan_q[CH_AW-1:BIT_W]};

  zs_bitmap #(.WORDS(BM_WORDS), .BW(BM_W)) bm_i (
    .clk   (clk),
    .we    (accept),
    .waddr (bm_waddr),
    .wbit  (chan_q[BIT_W-1:0]),
    .wval  (hit),
    .raddr (bm_raddr),
    .rdata (bm_rdata)
  );

  // next state
  always_comb begin
    st_n   = st_q;
    chan_n = chan_q;
    hits_n = hits_q;
    evt_n  = evt_q;
    if (trail_st) begin
      if (!fifo_full) begin
        st_n   = ST_RUN;
        hits_n = '0;
        evt_n  = evt_q + 1'b1;
      end
    end else if (accept) begin
      hits_n = hits_q + CNT_W'(hit);
      if (last_ch) begin
        chan_n = '0;
        st_n   = ST_TRAIL;
      end else begin
        chan_n = chan_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= ST_RUN;
      chan_q <= '0;
      hits_q <= '0;
      evt_q  <= '0;
    end else begin
      st_q   <= st_n;
      chan_q <= chan_n;
      hits_q <= hits_n;
      evt_q  <= evt_n;
    end
  end
endmodule

// File: rtl/zs_ped_proc_chk.sv
`timescale 1ns/1ps
module zs_ped_proc_chk #(
  parameter int OCC_W = 10,
  parameter int DEPTH = 512,
  parameter int EVT_W = 11,
  parameter int CNT_W = 7,
  parameter int N_CH  = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_ready,
  input logic             almost_full,
  input logic             trail_st,
  input logic             fifo_we,
  input logic [OCC_W-1:0] occ,
  input logic [EVT_W-1:0] evt,
  input logic [CNT_W-1:0] hits
);
  // R9
  afull_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    almost_full |-> !smp_ready);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH));

  // R10
  occ_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (occ == $past(occ)) || (occ == $past(occ) + 1'b1) || (occ == $past(occ) - 1'b1));

  // R5
  trail_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trail_st |-> !smp_ready);

  // R5
  trail_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_st && fifo_we) |=> !trail_st);

  // R7
  evt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_st && fifo_we) |=> (evt == $past(evt) + 1'b1));

  // R6
  hit_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hits <= CNT_W'(N_CH));
endmodule

bind zs_ped_proc zs_ped_proc_chk #(
  .OCC_W (OCC_W),
  .DEPTH (FIFO_DEPTH),
  .EVT_W (EVT_W),
  .CNT_W (CH_AW + 1),
  .N_CH  (N_CH)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_i_n),
  .smp_ready   (smp_ready),
  .almost_full (almost_full),
  .trail_st    (trail_st),
  .fifo_we     (fifo_we),
  .occ         (fifo_occ),
  .evt         (evt_q),
  .hits        (hits_q)
);

// File: tb/zs_ped_proc_tb_top.sv
`timescale 1ns/1ps
module zs_ped_proc_tb_top;
  logic        clk;
  logic        rst_n;
  logic        cfg_we, cfg_sel;
  logic [5:0]  cfg_addr;
  logic [11:0] cfg_wdata;
  logic [1:0]  cfg_groups;
  logic [9:0]  cfg_afull_lvl;
  logic        smp_valid;
  logic [11:0] smp_data;
  logic        smp_ready;
  logic        rd_en;
  logic [17:0] rd_data;
  logic        rd_trailer, fifo_empty, almost_full;
  logic [5:0]  bm_raddr;
  logic [15:0] bm_rdata;

  zs_ped_proc dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_groups(cfg_groups),
    .cfg_afull_lvl(cfg_afull_lvl), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_ready(smp_ready), .rd_en(rd_en), .rd_data(rd_data),
    .rd_trailer(rd_trailer), .fifo_empty(fifo_empty), .almost_full(almost_full),
    .bm_raddr(bm_raddr), .bm_rdata(bm_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference model state
  logic [18:0] mq[$];
  int          thr_m[64];
  int          ped_m[64];
  logic [15:0] bm_m[64];
  logic [15:0] bm_k[64];
  int          m_ch = 0, m_hits = 0, m_evt = 0;
  bit          m_trail = 0;
  int          lvl = 500, lvl_app = 500;
  int          grp = 2;
  bit          rd_mode = 1;
  int          cyc = 0;
  bit          cw_we = 0, cw_sel = 0;
  int          cw_addr = 0, cw_data = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one clock: compare outputs with the model, drive inputs, advance model
  task automatic step(input bit v, input logic [11:0] d, input bit rd, output bit acc);
    int  pre, a, b;
    bit  e_empty, e_af, e_rdy, hit;
    logic [11:0] amp;
    @(negedge clk);
    pre     = mq.size();
    e_empty = (pre == 0);
    e_af    = (pre >= lvl_app);
    e_rdy   = !m_trail && !e_af && (pre < 512);
    chk(fifo_empty == e_empty, "R10", "fifo_empty", fifo_empty, e_empty);
    chk(almost_full == e_af, "R9", "almost_full", almost_full, e_af);
    chk(smp_ready == e_rdy, "R5", "smp_ready", smp_ready, e_rdy);
    if (!e_empty)
      chk({rd_trailer, rd_data} == mq[0], mq[0][18] ? "R6" : "R2", "head word",
          {rd_trailer, rd_data}, mq[0]);
    bm_raddr = 6'(cyc % 64);
    #1;
    a = cyc % 64;
    if (bm_k[a] != 16'h0)
      chk((bm_rdata & bm_k[a]) == (bm_m[a] & bm_k[a]), "R8", "bitmap word",
          bm_rdata & bm_k[a], bm_m[a] & bm_k[a]);
    cyc++;
    // drive
    smp_valid     = v;
    smp_data      = d;
    rd_en         = rd;
    cfg_groups    = 2'(grp);
    cfg_afull_lvl = 10'(lvl);
    lvl_app       = lvl;
    cfg_we        = cw_we;
    cfg_sel       = cw_sel;
    cfg_addr      = 6'(cw_addr);
    cfg_wdata     = 12'(cw_data);
    // model
    acc = v && e_rdy;
    if (rd && !e_empty) void'(mq.pop_front());
    if (m_trail) begin
      if (pre < 512) begin
        mq.push_back({1'b1, 11'(m_evt), 7'(m_hits)});
        m_evt   = (m_evt + 1) % 2048;
        m_hits  = 0;
        m_trail = 0;
      end
    end else if (acc) begin
      hit = (int'(d) > thr_m[m_ch]);
      amp = (int'(d) > ped_m[m_ch]) ? 12'(int'(d) - ped_m[m_ch]) : 12'd0;
      if (hit) begin
        mq.push_back({1'b0, 6'(m_ch), amp});
        m_hits++;
      end
      a = (m_evt % 16) * 4 + m_ch / 16;
      b = m_ch % 16;
      bm_m[a][b] = hit;
      bm_k[a][b] = 1'b1;
      if (m_ch == (grp + 1) * 16 - 1) begin
        m_ch    = 0;
        m_trail = 1;
      end else m_ch++;
    end
    if (cw_we) begin
      if (cw_sel) ped_m[cw_addr] = cw_data & 255;
      else        thr_m[cw_addr] = cw_data;
    end
  endtask

  function automatic bit rd_pick();
    return rd_mode && ($urandom % 4 != 0);
  endfunction

  task automatic cfg_write(input bit sel, input int addr, input int data);
    bit acc;
    cw_we = 1; cw_sel = sel; cw_addr = addr; cw_data = data;
    step(0, 12'd0, rd_pick(), acc);
    cw_we = 0;
  endtask

  // mode 0: random full range, 1: at/above cut level, 2: near baseline, 3: all quiet
  function automatic logic [11:0] pick(input int mode, input int ch);
    int r;
    case (mode)
      0: r = $urandom % 4096;
      1: r = thr_m[ch] + (($urandom % 2 == 0) ? 0 : 1);
      2: r = ped_m[ch] + int'($urandom % 21) - 10;
      default: r = 0;
    endcase
    if (r < 0) r = 0;
    if (r > 4095) r = 4095;
    return 12'(r);
  endfunction

  task automatic run_event(input int mode);
    bit acc;
    logic [11:0] d;
    for (int ch = 0; ch < (grp + 1) * 16; ch++) begin
      d = pick(mode, ch);
      acc = 0;
      while (!acc) step(1, d, rd_pick(), acc);
    end
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) step(0, 12'd0, rd_pick(), acc);
  endtask

  initial begin
    bit acc;
    for (int i = 0; i < 64; i++) begin
      bm_k[i] = '0; bm_m[i] = '0; thr_m[i] = 0; ped_m[i] = 0;
    end
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_addr = 0; cfg_wdata = 0;
    cfg_groups = 2'd2; cfg_afull_lvl = 10'd500; smp_valid = 0; smp_data = 0;
    rd_en = 0; bm_raddr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #1;
    // R1: state after reset
    chk(fifo_empty == 1'b1, "R1", "fifo_empty after reset", fifo_empty, 1);
    chk(almost_full == 1'b0, "R1", "almost_full after reset", almost_full, 0);
    chk(smp_ready == 1'b1, "R1", "smp_ready after reset", smp_ready, 1);

    // R11: baseline writes carry junk in the upper nibble
    for (int i = 0; i < 64; i++) begin
      int p, t;
      p = 20 + (i * 7) % 200;
      t = (i % 8 == 5) ? p - 10 : p + 3 * (1 + i % 5);
      cfg_write(1, i, 'hA00 | p);
      cfg_write(0, i, t);
    end

    // R2 R3 R4 R8: 48-channel events under several patterns
    rd_mode = 1; grp = 2;
    run_event(0); run_event(1); run_event(2); run_event(0);
    // R5: other event lengths
    grp = 0; run_event(0); run_event(2);
    grp = 1; run_event(1); run_event(0);
    grp = 3; run_event(0); run_event(2); run_event(1);
    idle(300);

    // R9: intake stalls at the fill level and resumes as the reader drains
    lvl = 40; rd_mode = 0; grp = 3;
    for (int i = 0; i < 120; i++) step(1, 12'hFFF, 0, acc);
    rd_mode = 1;
    while (m_ch != 0 || m_trail) step(1, 12'hFFF, rd_pick(), acc);
    idle(200);
    lvl = 500;

    // R7: event number wrap over 2048 short events
    grp = 0;
    for (int e = 0; e < 2060; e++) run_event((e % 64 == 0) ? 0 : 3);
    rd_mode = 1;
    idle(300);
    chk(fifo_empty == 1'b1, "R10", "drained at end", fifo_empty, 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule